// File: doc/BRIEF.md
# Addressed Chip-Enable Serial Port for a Segment Display Driver

This block is the host-facing serial port of a small segment display and keypad controller. The host frames each transfer with a chip-enable line. It clocks data on a bit clock and drives a data-in line. After chip-enable rises, the first byte is a bus address, sent least significant bit first. Address 0x42 opens a write and address 0x43 opens a read. Any other address makes the port ignore the rest of the transfer. The three host lines are asynchronous to the system clock. Each passes through a two-flop synchroniser before its edges are detected, and data-in is sampled on rising bit-clock edges.

A write carries 32 bits after the address: half of the display bits, seven control bits, and a direction bit last. The direction bit names which half of the display the frame carries. A frame is latched into the display and control registers when chip-enable falls, and only if it holds exactly 32 bits. The port keeps the rest of the chip in system reset until both halves have been received. The key scanner hands over a 20-bit key code. Once reset is released, the port then pulls its data-out line low as a read request. A read returns the 20 key bits followed by a sleep-acknowledge bit, and it withdraws the request when chip-enable falls.

Top module: `ce_serial_port`

## Requirements
- R1: After `rst_n` is released, `sys_rst_o` is 1, `do_o` is 1 and no read request is pending.
- R2: A write with address 0x42 and exactly 32 data bits, last bit (direction) 0, loads data bits 0..23 into `disp_o[23:0]` when CE falls. Bits 24,25 go to `sleep_o[0]`,`sleep_o[1]`, bits 26,27 to `strobe_o[0]`,`strobe_o[1]`, and bits 28..30 to `port_o[0..2]`.
- R3: A write with direction bit 1 loads data bits 0..23 into `disp_o[47:24]`, bit 24 into `blank_o` and bit 25 into `bias_half_o`. Bits 26..30 are don't-care.
- R4: A transfer whose address is neither 0x42 nor 0x43 is ignored, and so is a write frame with any bit count other than 32. Display, control and reset outputs keep their values.
- R5: `sys_rst_o` goes to 0 on the CE fall that completes the second of the two direction frames, in either order. One direction alone leaves it at 1.
- R6: A `key_load_i` pulse while `sys_rst_o` is 0 stores `key_code_i` and raises a request: `do_o` is 0 whenever CE is low. While `sys_rst_o` is 1 the pulse is ignored and `do_o` stays 1.
- R7: While CE is high and the transfer is not in its read data phase, `do_o` is 1, even with a request pending.
- R8: In a read (address 0x43), `do_o` shows KD1 (key_code bit 0) right after the eighth address clock. Each later CL rise advances it by one bit, through KD20, then the sleep-acknowledge bit. Sleep-acknowledge is 1 when `sleep_o` is non-zero and 0 otherwise.
- R9: The CE fall that ends a read withdraws the request, so `do_o` returns to 1.
- R10: `read_stale_o` takes a new value at the start of each read's data phase: 1 if no request was pending, 0 if one was.
- R11: A write that changes `sleep_o` while a request is pending takes effect: the request stays pending and the next read returns the new sleep-acknowledge value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| ce_i | input | 1 | Chip enable, asynchronous |
| cl_i | input | 1 | Serial bit clock, asynchronous |
| di_i | input | 1 | Serial data in, asynchronous |
| key_load_i | input | 1 | One-cycle strobe: key scanner has a confirmed code |
| key_code_i | input | 20 | Key code, bit 0 is KD1 |
| do_o | output | 1 | Data out / request level, 0 pulls the line low |
| sys_rst_o | output | 1 | System reset for the display and key scan logic |
| disp_o | output | 48 | Display bits |
| sleep_o | output | 2 | Sleep select field |
| strobe_o | output | 2 | Strobe/segment select field |
| port_o | output | 3 | General-purpose port select field |
| blank_o | output | 1 | Segments blanked |
| bias_half_o | output | 1 | Half-bias drive selected |
| read_stale_o | output | 1 | Last read began with no request pending |

## Verification
The bench sends frames one bit short, one bit long and with a wrong address. A port that counted loosely or matched the address partially would overwrite the display or release reset early. It raises a key strobe during reset, and a design that failed to gate it would pull data-out low before the display is configured. It writes a new sleep mode while a request is pending. It then reads twice, so a design that took the acknowledge bit from a stale copy, or failed to withdraw the request on the closing CE fall, shows a wrong bit or a data-out line stuck low. It also checks the first data bit right after the address, where an off-by-one shifter would present KD2.

// File: rtl/ceport_pkg.sv
package ceport_pkg;

  localparam int CTRL_W = 7;

  typedef enum logic [1:0] {
    XF_ADDR  = 2'd0,
    XF_WRITE = 2'd1,
    XF_READ  = 2'd2,
    XF_SKIP  = 2'd3
  } xfer_kind_e;

  typedef struct packed {
    logic [1:0] sleep;
    logic [1:0] strobe;
    logic [2:0] port;
    logic       blank;
    logic       bias_half;
  } ctrl_t;

  function automatic logic count_hits(int unsigned cnt, int unsigned need);
    return cnt == need;
  endfunction

  function automatic logic sleep_ack(logic [1:0] sleep);
    return |sleep;
  endfunction

endpackage

// File: rtl/ceport_sync.sv
module ceport_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  logic [STAGES:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[STAGES-1:0], async_i};
  end

  assign lvl_o  = stage_q[STAGES-1];
  assign rise_o = stage_q[STAGES-1] & ~stage_q[STAGES];
  assign fall_o = ~stage_q[STAGES-1] & stage_q[STAGES];

endmodule

// File: rtl/ceport_rx.sv
module ceport_rx
  import ceport_pkg::*;
#(
  parameter int                   FRAME_BITS = 32,
  parameter int                   ADDR_BITS  = 8,
  parameter logic [ADDR_BITS-1:0] WR_ADDR    = 'h42,
  parameter logic [ADDR_BITS-1:0] RD_ADDR    = 'h43
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ce_lvl_i,
  input  logic                  ce_rise_i,
  input  logic                  ce_fall_i,
  input  logic                  cl_rise_i,
  input  logic                  di_lvl_i,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  frame_ok_o,
  output logic                  rd_start_o,
  output logic                  rd_shift_o,
  output logic                  rd_end_o,
  output logic                  in_rd_o
);

  localparam int ACW = $clog2(ADDR_BITS + 1);
  localparam int DCW = $clog2(FRAME_BITS + 2);

  logic [ADDR_BITS-1:0]  addr_sr;
  logic [ADDR_BITS-1:0]  next_addr;
  logic [FRAME_BITS-1:0] frame_sr;
  logic [ACW-1:0]        addr_cnt;
  logic [DCW-1:0]        data_cnt;
  xfer_kind_e            kind_q;
  xfer_kind_e            next_kind;
  logic                  bit_clk;
  logic                  addr_last;

  function automatic xfer_kind_e decode_addr(logic [ADDR_BITS-1:0] a);
    if (a == WR_ADDR) return XF_WRITE;
    if (a == RD_ADDR) return XF_READ;
    return XF_SKIP;
  endfunction

  assign bit_clk   = ce_lvl_i && cl_rise_i;
  assign next_addr = {di_lvl_i, addr_sr[ADDR_BITS-1:1]};
  assign next_kind = decode_addr(next_addr);
  assign addr_last = bit_clk && (kind_q == XF_ADDR) &&
                     (int'(addr_cnt) == ADDR_BITS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q   <= XF_ADDR;
      addr_cnt <= '0;
      data_cnt <= '0;
    end else if (ce_rise_i) begin
      kind_q   <= XF_ADDR;
      addr_cnt <= '0;
      data_cnt <= '0;
    end else if (ce_fall_i) begin
      kind_q <= XF_ADDR;
    end else if (bit_clk) begin
      case (kind_q)
        XF_ADDR: begin
          addr_cnt <= addr_cnt + 1'b1;
          if (addr_last) kind_q <= next_kind;
        end
        XF_WRITE: begin
          if (int'(data_cnt) <= FRAME_BITS) data_cnt <= data_cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // shift registers carry no reset
  always_ff @(posedge clk) begin
    if (bit_clk && kind_q == XF_ADDR)  addr_sr  <= next_addr;
    if (bit_clk && kind_q == XF_WRITE) frame_sr <= {di_lvl_i, frame_sr[FRAME_BITS-1:1]};
  end

  assign frame_o    = frame_sr;
  assign frame_ok_o = ce_fall_i && (kind_q == XF_WRITE) &&
                      count_hits(int'(data_cnt), FRAME_BITS);
  assign rd_start_o = addr_last && (next_kind == XF_READ);
  assign rd_shift_o = bit_clk && (kind_q == XF_READ);
  assign rd_end_o   = ce_fall_i && (kind_q == XF_READ);
  assign in_rd_o    = (kind_q == XF_READ);

  // R4: every transfer starts counting data bits from zero
  p_ce_rise_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ce_rise_i |=> (data_cnt == '0));

endmodule

// File: rtl/ceport_regs.sv
module ceport_regs
  import ceport_pkg::*;
#(
  parameter int HALF = 24,
  localparam int FB  = HALF + CTRL_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FB-1:0]   frame_i,
  input  logic            frame_ok_i,
  output logic [2*HALF-1:0] disp_o,
  output ctrl_t           ctrl_o,
  output logic            sys_rst_o
);

  logic              frame_dir;
  logic [CTRL_W-1:0] ctrl_a_q;
  logic [1:0]        ctrl_b_q;
  logic [1:0]        got_q;
  logic [1:0]        got_next;
  logic              sys_rst_q;

  assign frame_dir = frame_i[FB-1];

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF-1:0] half_q;
    always_ff @(posedge clk) begin
      if (frame_ok_i && (int'(frame_dir) == h)) half_q <= frame_i[HALF-1:0];
    end
    assign disp_o[h*HALF +: HALF] = half_q;
  end

  always_ff @(posedge clk) begin
    if (frame_ok_i && !frame_dir) ctrl_a_q <= frame_i[HALF +: CTRL_W];
    if (frame_ok_i &&  frame_dir) ctrl_b_q <= frame_i[HALF +: 2];
  end

  always_comb begin
    ctrl_o.sleep     = ctrl_a_q[1:0];
    ctrl_o.strobe    = ctrl_a_q[3:2];
    ctrl_o.port      = ctrl_a_q[6:4];
    ctrl_o.blank     = ctrl_b_q[0];
    ctrl_o.bias_half = ctrl_b_q[1];
  end

  assign got_next = got_q | (frame_dir ? 2'b10 : 2'b01);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got_q     <= 2'b00;
      sys_rst_q <= 1'b1;
    end else if (frame_ok_i) begin
      got_q <= got_next;
      if (got_next == 2'b11) sys_rst_q <= 1'b0;
    end
  end

  assign sys_rst_o = sys_rst_q;

  // R2: display bits move only after an accepted frame
  p_disp_on_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(disp_o) |-> $past(frame_ok_i));

  // R5: reset is released only by an accepted frame
  p_release_on_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_q) |-> $past(frame_ok_i));

endmodule

// File: rtl/ceport_keyrd.sv
module ceport_keyrd #(
  parameter int KEY_BITS = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sys_rst_i,
  input  logic                key_load_i,
  input  logic [KEY_BITS-1:0] key_code_i,
  input  logic                sa_i,
  input  logic                rd_start_i,
  input  logic                rd_shift_i,
  input  logic                rd_end_i,
  output logic                req_o,
  output logic                out_bit_o,
  output logic                stale_o
);

  localparam int OUT_W = KEY_BITS + 1;

  logic [KEY_BITS-1:0] key_buf_q;
  logic [OUT_W-1:0]    out_sr_q;
  logic                req_q;
  logic                stale_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_buf_q <= '0;
      req_q     <= 1'b0;
    end else if (sys_rst_i) begin
      key_buf_q <= '0;
      req_q     <= 1'b0;
    end else if (key_load_i) begin
      key_buf_q <= key_code_i;
      req_q     <= 1'b1;
    end else if (rd_end_i) begin
      req_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sr_q <= '1;
      stale_q  <= 1'b0;
    end else if (rd_start_i) begin
      out_sr_q <= {sa_i, key_buf_q};
      stale_q  <= !req_q;
    end else if (rd_shift_i) begin
      out_sr_q <= {1'b0, out_sr_q[OUT_W-1:1]};
    end
  end

  assign req_o     = req_q;
  assign out_bit_o = out_sr_q[0];
  assign stale_o   = stale_q;

  // R6: no request survives a cycle of system reset
  p_no_req_in_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_i |=> !req_q);

  // R9: a request is withdrawn only by the end of a read (or reset)
  p_req_drop_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_q) |-> $past(rd_end_i || sys_rst_i));

  // R10: stale flag changes only at the start of a read data phase
  p_stale_at_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stale_q) |-> $past(rd_start_i));

endmodule

// File: rtl/ce_serial_port.sv
module ce_serial_port
  import ceport_pkg::*;
#(
  parameter int                   DISP_BITS   = 48,
  parameter int                   KEY_BITS    = 20,
  parameter int                   SYNC_STAGES = 2,
  parameter int                   ADDR_BITS   = 8,
  parameter logic [ADDR_BITS-1:0] WR_ADDR     = 'h42,
  parameter logic [ADDR_BITS-1:0] RD_ADDR     = 'h43
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce_i,
  input  logic                 cl_i,
  input  logic                 di_i,
  input  logic                 key_load_i,
  input  logic [KEY_BITS-1:0]  key_code_i,
  output logic                 do_o,
  output logic                 sys_rst_o,
  output logic [DISP_BITS-1:0] disp_o,
  output logic [1:0]           sleep_o,
  output logic [1:0]           strobe_o,
  output logic [2:0]           port_o,
  output logic                 blank_o,
  output logic                 bias_half_o,
  output logic                 read_stale_o
);

  localparam int HALF       = DISP_BITS / 2;
  localparam int FRAME_BITS = HALF + CTRL_W + 1;

  logic [2:0] s_lvl, s_rise, s_fall;
  logic       ce_lvl, ce_rise, ce_fall, cl_rise, di_lvl;
  logic       unused_sync_edges;

  logic [FRAME_BITS-1:0] frame;
  logic  frame_ok, rd_start, rd_shift, rd_end, in_rd;
  logic  sys_rst, req_pend, out_bit, stale;
  ctrl_t ctrl;

  ceport_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({di_i, cl_i, ce_i}),
    .lvl_o  (s_lvl),
    .rise_o (s_rise),
    .fall_o (s_fall)
  );

  assign ce_lvl  = s_lvl[0];
  assign ce_rise = s_rise[0];
  assign ce_fall = s_fall[0];
  assign cl_rise = s_rise[1];
  assign di_lvl  = s_lvl[2];
  assign unused_sync_edges = ^{s_lvl[1], s_fall[2:1], s_rise[2]};

  ceport_rx #(
    .FRAME_BITS(FRAME_BITS),
    .ADDR_BITS (ADDR_BITS),
    .WR_ADDR   (WR_ADDR),
    .RD_ADDR   (RD_ADDR)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_lvl_i  (ce_lvl),
    .ce_rise_i (ce_rise),
    .ce_fall_i (ce_fall),
    .cl_rise_i (cl_rise),
    .di_lvl_i  (di_lvl),
    .frame_o   (frame),
    .frame_ok_o(frame_ok),
    .rd_start_o(rd_start),
    .rd_shift_o(rd_shift),
    .rd_end_o  (rd_end),
    .in_rd_o   (in_rd)
  );

  ceport_regs #(.HALF(HALF)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_i   (frame),
    .frame_ok_i(frame_ok),
    .disp_o    (disp_o),
    .ctrl_o    (ctrl),
    .sys_rst_o (sys_rst)
  );

  ceport_keyrd #(.KEY_BITS(KEY_BITS)) u_keyrd (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_rst_i (sys_rst),
    .key_load_i(key_load_i),
    .key_code_i(key_code_i),
    .sa_i      (sleep_ack(ctrl.sleep)),
    .rd_start_i(rd_start),
    .rd_shift_i(rd_shift),
    .rd_end_i  (rd_end),
    .req_o     (req_pend),
    .out_bit_o (out_bit),
    .stale_o   (stale)
  );

  always_comb begin
    if (sys_rst)     do_o = 1'b1;
    else if (ce_lvl) do_o = in_rd ? out_bit : 1'b1;
    else             do_o = ~req_pend;
  end

  assign sys_rst_o    = sys_rst;
  assign sleep_o      = ctrl.sleep;
  assign strobe_o     = ctrl.strobe;
  assign port_o       = ctrl.port;
  assign blank_o      = ctrl.blank;
  assign bias_half_o  = ctrl.bias_half;
  assign read_stale_o = stale;

endmodule

// File: tb/ce_serial_port_tb.sv
`timescale 1ns/1ps
module ce_serial_port_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b0, cl = 1'b0, di = 1'b0;
  logic        key_load = 1'b0;
  logic [19:0] key_code = '0;
  logic        do_o, sys_rst_o, blank_o, bias_half_o, read_stale_o;
  logic [47:0] disp_o;
  logic [1:0]  sleep_o, strobe_o;
  logic [2:0]  port_o;

  always #2.5 clk = ~clk;

  ce_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .cl_i(cl), .di_i(di),
    .key_load_i(key_load), .key_code_i(key_code), .do_o(do_o),
    .sys_rst_o(sys_rst_o), .disp_o(disp_o), .sleep_o(sleep_o),
    .strobe_o(strobe_o), .port_o(port_o), .blank_o(blank_o),
    .bias_half_o(bias_half_o), .read_stale_o(read_stale_o)
  );

  int total = 0, bad = 0, quiet = 0;
  bit run_mon = 0, in_read = 0;
  string cur_req = "R1";

  // reference model state
  bit          exp_rst = 1, exp_req = 0, exp_stale = 0;
  bit [1:0]    got = 2'b00;
  bit          seen_a = 0, seen_b = 0;
  bit [23:0]   exp_lo, exp_hi;
  bit [1:0]    exp_sleep, exp_strobe;
  bit [2:0]    exp_port;
  bit          exp_blank, exp_bias;
  bit [19:0]   exp_key = '0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  always @(negedge clk) begin
    quiet++;
    if (run_mon && quiet >= 6) begin
      chk(cur_req, sys_rst_o, exp_rst, "sys_rst");
      if (!in_read) begin
        chk(cur_req, do_o, (exp_rst || ce) ? 1'b1 : !exp_req, "do");
        chk(cur_req, read_stale_o, exp_stale, "stale");
      end
      if (seen_a) begin
        chk(cur_req, disp_o[23:0], exp_lo, "disp_lo");
        chk(cur_req, {sleep_o, strobe_o, port_o}, {exp_sleep, exp_strobe, exp_port}, "ctrl_a");
      end
      if (seen_b) begin
        chk(cur_req, disp_o[47:24], exp_hi, "disp_hi");
        chk(cur_req, {blank_o, bias_half_o}, {exp_blank, exp_bias}, "ctrl_b");
      end
    end
  end

  task automatic send_bit(bit b);
    di = b; quiet = 0; tick(8);
    cl = 1'b1; quiet = 0; tick(8);
    cl = 1'b0; quiet = 0; tick(8);
  endtask

  task automatic ce_up();
    ce = 1'b1; quiet = 0; tick(8);
  endtask

  task automatic send_addr7(bit [7:0] a);
    for (int i = 0; i < 7; i++) send_bit(a[i]);
  endtask

  task automatic wr(bit [7:0] addr, bit dir, bit [23:0] d, bit [6:0] c, int nbits,
                    bit chk_do = 0);
    bit [31:0] fr;
    fr = {dir, c, d};
    ce_up();
    send_addr7(addr);
    send_bit(addr[7]);
    for (int i = 0; i < nbits; i++) begin
      send_bit(i < 32 ? fr[i] : 1'b0);
      if (chk_do && i == 10) chk("R7", do_o, 1'b1, "do high during write");
    end
    ce = 1'b0; quiet = 0;
    if (addr == 8'h42 && nbits == 32) begin
      got[dir] = 1'b1;
      if (!dir) begin
        exp_lo = d; exp_sleep = c[1:0]; exp_strobe = c[3:2]; exp_port = c[6:4];
        seen_a = 1;
      end else begin
        exp_hi = d; exp_blank = c[0]; exp_bias = c[1];
        seen_b = 1;
      end
      if (got == 2'b11) exp_rst = 0;
    end
    tick(8);
  endtask

  task automatic rd(string tag);
    bit [20:0] eb;
    ce_up();
    send_addr7(8'h43);
    eb = {(exp_sleep != 2'b00), exp_key};
    in_read = 1;
    exp_stale = !exp_req;
    send_bit(1'b0);
    for (int i = 0; i < 21; i++) begin
      chk(tag, do_o, exp_rst ? 1'b1 : eb[i], $sformatf("read bit %0d", i));
      send_bit(1'b0);
    end
    chk("R10", read_stale_o, exp_stale, "stale after read start");
    ce = 1'b0; quiet = 0;
    in_read = 0;
    exp_req = 0;
    tick(8);
  endtask

  task automatic key(bit [19:0] code);
    key_code = code; key_load = 1'b1; quiet = 0;
    tick(1);
    key_load = 1'b0;
    if (!exp_rst) begin exp_req = 1; exp_key = code; end
    tick(10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(10);
    run_mon = 1;
    cur_req = "R1";
    chk("R1", sys_rst_o, 1'b1, "reset state sys_rst");
    chk("R1", do_o, 1'b1, "reset state do");

    cur_req = "R6";
    key(20'hFFFFF);
    chk("R6", do_o, 1'b1, "key strobe in reset ignored");

    cur_req = "R2";
    wr(8'h42, 1'b0, 24'hA5C3F0, 7'b011_01_00, 32);
    chk("R2", disp_o[23:0], 24'hA5C3F0, "disp low half");
    chk("R2", {port_o, strobe_o, sleep_o}, 7'b011_01_00, "control group A");
    chk("R5", sys_rst_o, 1'b1, "one direction only keeps reset");

    cur_req = "R4";
    wr(8'h42, 1'b1, 24'h111111, 7'b0000011, 31);
    chk("R4", sys_rst_o, 1'b1, "short frame ignored");
    wr(8'h44, 1'b1, 24'h222222, 7'b0000011, 32);
    chk("R4", sys_rst_o, 1'b1, "wrong address ignored");

    cur_req = "R3";
    wr(8'h42, 1'b1, 24'h13579B, 7'b0000011, 32);
    chk("R3", disp_o[47:24], 24'h13579B, "disp high half");
    chk("R3", {bias_half_o, blank_o}, 2'b11, "blank and bias");
    chk("R5", sys_rst_o, 1'b0, "reset released after both frames");

    cur_req = "R4";
    wr(8'h42, 1'b1, 24'hFEDCBA, 7'b0000000, 33);
    chk("R4", disp_o[47:24], 24'h13579B, "long frame ignored");

    cur_req = "R6";
    key(20'hA5A5A);
    chk("R6", do_o, 1'b0, "request pulls do low");

    cur_req = "R11";
    wr(8'h42, 1'b0, 24'h0F0F0F, 7'b000_00_10, 32, 1'b1);
    chk("R11", sleep_o, 2'b10, "sleep written while pending");
    chk("R11", do_o, 1'b0, "request survives write");

    cur_req = "R8";
    rd("R8");
    chk("R9", do_o, 1'b1, "request withdrawn by read");
    chk("R10", read_stale_o, 1'b0, "read with request not stale");

    cur_req = "R10";
    rd("R10");
    chk("R10", read_stale_o, 1'b1, "read without request stale");

    cur_req = "R8";
    wr(8'h42, 1'b0, 24'h0F0F0F, 7'b000_00_00, 32);
    key(20'h00F0F);
    rd("R8");
    chk("R9", do_o, 1'b1, "do high after second read");

    tick(20);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule